// File: doc/BRIEF.md
# Multiprocessor Interrupt and Miscellaneous Control Register

This block is one 64-bit control register shared by up to four processors. Each field of the register has its own write behaviour. Some fields clear when a one is written to them. Some set when a one is written. One field sets only while it is still empty. One field holds exactly what was last written. A group of request bits is never stored: each request bit raises the pending interprocessor interrupt of one processor.

The register drives two level outputs per processor. One is the interprocessor interrupt and the other is the interval-timer interrupt. A per-processor timer input raises the timer interrupt, and software clears it by writing to the register. A read always returns the current register value, with the reading processor's 2-bit index placed in bits [1:0]. That lets the reader learn which processor it is. The two 4-bit arbitration fields are only stored and drive no arbiter. Every bit not listed below reads as zero, except a fixed revision bit.

Top module: `mp_ctl_reg`

## Requirements
- R1: After reset the stored value is 0x0000_0008_0000_0000 (bit 35 set as a revision code, every other bit zero), and all interrupt outputs are low.
- R2: `rd_data` equals the stored value with `rd_cpu` ORed into bits [1:0], in the same cycle that `rd_cpu` is driven.
- R3: A write with a one in any of bits 4–11 clears that stored bit. Bit 28 is write-one-to-clear and always reads zero.
- R4: A write with bit 20 set clears bits 16–23, whatever else that write carries.
- R5: A write with bit 20 clear sets each of bits 20–23 whose written bit is one.
- R6: A write with bit 20 clear ORs written bits 16–19 into the register only while stored bits 16–19 are all zero; otherwise those bits are left unchanged.
- R7: A write bit 12+i (i = 0..3) sets stored bit 8+i. A request wins over a clear of the same bit in the same write.
- R8: Bits 40–43 take the written value on every write.
- R9: `ipi_o[i]` follows stored bit 8+i and `iti_o[i]` follows stored bit 4+i.
- R10: `timer_set[i]` high at a clock edge sets stored bit 4+i. It wins over a clear of that bit written in the same cycle.
- R11: Writes leave bit 35 and every bit outside the fields above unchanged, so those bits read as zero; the request bits 12–15 are never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 64 | Write value |
| rd_cpu | input | 2 | Index of the reading processor |
| rd_data | output | 64 | Register value with the index in [1:0] |
| timer_set | input | 4 | Per-processor timer interrupt set |
| ipi_o | output | 4 | Per-processor interprocessor interrupt level |
| iti_o | output | 4 | Per-processor interval-timer interrupt level |

## Verification
A write or a `timer_set` pulse takes effect at the first rising edge after it is driven. The change then shows on `rd_data`, `ipi_o` and `iti_o` from that edge on. The read path has no register, so `rd_data` follows `rd_cpu` in the same cycle. The bench drives every input on a falling edge and samples results on the next falling edge. Every check therefore falls one full edge after the update it expects, and never close to a rising edge.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
   localparam int REG_W        = 64;
   localparam int IDX_W        = 2;
   localparam int MAX_CPU      = 4;
   localparam int TMR_LSB      = 4;
   localparam int IPI_LSB      = 8;
   localparam int REQ_LSB      = 12;
   localparam int ARB_LSB      = 16;
   localparam int ARB_W        = 8;
   localparam int ARB_FLUSH    = 4;
   localparam int LOCK_BIT     = 28;
   localparam int REV_BIT      = 35;
   localparam int PLAIN_LSB    = 40;
   localparam int PLAIN_W      = 4;
endpackage

// File: rtl/mpc_cpu_irq.sv
module mpc_cpu_irq #(
   parameter int NCPU = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [NCPU-1:0] tmr_clr,
   input  logic [NCPU-1:0] ipi_clr,
   input  logic [NCPU-1:0] ipi_req,
   input  logic [NCPU-1:0] tmr_set,
   output logic [NCPU-1:0] tmr_q,
   output logic [NCPU-1:0] ipi_q
);
   for (genvar i = 0; i < NCPU; i++) begin : g_cpu
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tmr_q[i] <= 1'b0;
         end else if (tmr_set[i]) begin
            tmr_q[i] <= 1'b1;
         end else if (wr_en && tmr_clr[i]) begin
            tmr_q[i] <= 1'b0;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ipi_q[i] <= 1'b0;
         end else if (wr_en) begin
            ipi_q[i] <= (ipi_q[i] & ~ipi_clr[i]) | ipi_req[i];
         end
      end

      // R10
      tmr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tmr_set[i] |=> tmr_q[i]);
      // R7
      ipi_req_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && ipi_req[i]) |=> ipi_q[i]);
      // R3
      ipi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && ipi_clr[i] && !ipi_req[i]) |=> !ipi_q[i]);
   end
endmodule

// File: rtl/mpc_arb_field.sv
module mpc_arb_field #(
   parameter int FW    = 8,
   parameter int FLUSH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [FW-1:0] wd,
   output logic [FW-1:0] q
);
   localparam int HALF = FW / 2;

   logic [HALF-1:0] lo_nxt, hi_nxt;

   always_comb begin
      if (wd[FLUSH]) begin
         lo_nxt = '0;
         hi_nxt = '0;
      end else begin
         hi_nxt = q[FW-1:HALF] | wd[FW-1:HALF];
         lo_nxt = (q[HALF-1:0] == '0) ? wd[HALF-1:0] : q[HALF-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en) begin
         q <= {hi_nxt, lo_nxt};
      end
   end

   // R4
   arb_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wd[FLUSH]) |=> (q == '0));
   // R6
   arb_lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wd[FLUSH] && (q[HALF-1:0] != '0)) |=> $stable(q[HALF-1:0]));
endmodule

// File: rtl/mpc_plain_field.sv
module mpc_plain_field #(
   parameter int FW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [FW-1:0] wd,
   output logic [FW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en) begin
         q <= wd;
      end
   end

   // R8
   plain_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (q == $past(wd)));
endmodule

// File: rtl/mp_ctl_reg.sv
module mp_ctl_reg
   import mpc_pkg::*;
#(
   parameter int NCPU = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_W-1:0]      wr_data,
   input  logic [IDX_W-1:0]      rd_cpu,
   output logic [REG_W-1:0]      rd_data,
   input  logic [MAX_CPU-1:0]    timer_set,
   output logic [MAX_CPU-1:0]    ipi_o,
   output logic [MAX_CPU-1:0]    iti_o
);
   localparam int SPARE = MAX_CPU - NCPU;

   if (NCPU < 1 || NCPU > MAX_CPU) begin : g_bad_ncpu
      initial $fatal(1, "NCPU must be 1..%0d", MAX_CPU);
   end

   logic [NCPU-1:0]    tmr_q, ipi_q;
   logic [ARB_W-1:0]   arb_q;
   logic [PLAIN_W-1:0] plain_q;
   logic [REG_W-1:0]   reg_q;

   mpc_cpu_irq #(.NCPU(NCPU)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .tmr_clr (wr_data[TMR_LSB +: NCPU]),
      .ipi_clr (wr_data[IPI_LSB +: NCPU]),
      .ipi_req (wr_data[REQ_LSB +: NCPU]),
      .tmr_set (timer_set[NCPU-1:0]),
      .tmr_q   (tmr_q),
      .ipi_q   (ipi_q)
   );

   mpc_arb_field #(.FW(ARB_W), .FLUSH(ARB_FLUSH)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .wd    (wr_data[ARB_LSB +: ARB_W]),
      .q     (arb_q)
   );

   mpc_plain_field #(.FW(PLAIN_W)) u_plain (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .wd    (wr_data[PLAIN_LSB +: PLAIN_W]),
      .q     (plain_q)
   );

   always_comb begin
      reg_q                       = '0;
      reg_q[TMR_LSB +: NCPU]      = tmr_q;
      reg_q[IPI_LSB +: NCPU]      = ipi_q;
      reg_q[ARB_LSB +: ARB_W]     = arb_q;
      reg_q[PLAIN_LSB +: PLAIN_W] = plain_q;
      reg_q[REV_BIT]              = 1'b1;
   end

   assign rd_data = reg_q | {{(REG_W-IDX_W){1'b0}}, rd_cpu};

   if (SPARE > 0) begin : g_spare
      assign ipi_o = {{SPARE{1'b0}}, ipi_q};
      assign iti_o = {{SPARE{1'b0}}, tmr_q};
      logic unused_tset;
      assign unused_tset = ^timer_set[MAX_CPU-1:NCPU];
   end else begin : g_full
      assign ipi_o = ipi_q;
      assign iti_o = tmr_q;
   end

   logic unused_wbits;
   assign unused_wbits = ^{wr_data[REG_W-1:PLAIN_LSB+PLAIN_W],
                           wr_data[PLAIN_LSB-1:ARB_LSB+ARB_W],
                           wr_data[TMR_LSB-1:0]};

   // R11
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && timer_set == '0) |=> $stable(rd_data[REG_W-1:IDX_W]));
   // R2
   rd_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[IDX_W-1:0] == rd_cpu);
endmodule

// File: tb/mp_ctl_reg_tb.sv
`timescale 1ns/1ps
module mp_ctl_reg_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic [1:0]  rd_cpu = '0;
   logic [63:0] rd_data;
   logic [3:0]  timer_set = '0;
   logic [3:0]  ipi_o, iti_o;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   localparam logic [63:0] REV = 64'h0000_0008_0000_0000;

   always #10 clk = ~clk;

   mp_ctl_reg u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_cpu(rd_cpu), .rd_data(rd_data), .timer_set(timer_set),
      .ipi_o(ipi_o), .iti_o(iti_o)
   );

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [63:0] v, logic [3:0] ts = 4'b0);
      @(negedge clk);
      wr_en = 1'b1; wr_data = v; timer_set = ts;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; timer_set = '0;
   endtask

   task automatic rd_chk(string req, logic [63:0] exp);
      rd_cpu = 2'd0;
      #1 chk(req, rd_data, exp);
   endtask

   task automatic t_reset;
      rd_chk("R1 reset value", REV);
      chk("R1 ipi reset", {60'b0, ipi_o}, 64'h0);
      chk("R1 iti reset", {60'b0, iti_o}, 64'h0);
   endtask

   task automatic t_index;
      rd_cpu = 2'd3;
      #1 chk("R2 index 3", rd_data, REV | 64'h3);
      rd_cpu = 2'd2;
      #1 chk("R2 index 2", rd_data, REV | 64'h2);
      rd_cpu = 2'd0;
   endtask

   task automatic t_timer;
      @(negedge clk); timer_set = 4'b0101;
      @(negedge clk); timer_set = 4'b0000;
      chk("R10 R9 timer set", {60'b0, iti_o}, 64'h5);
      rd_chk("R10 timer bits", REV | 64'h50);
      wr(64'h10);
      chk("R3 timer clear cpu0", {60'b0, iti_o}, 64'h4);
      wr(64'h40, 4'b0100);
      chk("R10 set wins over clear", {60'b0, iti_o}, 64'h4);
      wr(64'h40);
      chk("R3 timer clear cpu2", {60'b0, iti_o}, 64'h0);
   endtask

   task automatic t_ipi;
      wr(64'hA000);
      chk("R7 R9 ipi request", {60'b0, ipi_o}, 64'hA);
      rd_chk("R7 ipi stored", REV | 64'hA00);
      wr(64'h2200);
      chk("R7 request wins over clear", {60'b0, ipi_o}, 64'hA);
      wr(64'h0A00);
      chk("R3 ipi clear", {60'b0, ipi_o}, 64'h0);
   endtask

   task automatic t_arb;
      wr(64'h00A0_0000);
      rd_chk("R5 high nibble set", REV | 64'h00A0_0000);
      wr(64'h0005_0000);
      rd_chk("R6 low nibble set when empty", REV | 64'h00A5_0000);
      wr(64'h000A_0000);
      rd_chk("R6 low nibble held when nonzero", REV | 64'h00A5_0000);
      wr(64'h0010_0000);
      rd_chk("R4 flush", REV);
      wr(64'h0031_0000);
      rd_chk("R4 flush beats set", REV);
   endtask

   task automatic t_plain;
      wr(64'h0000_0A00_0000_0000);
      rd_chk("R8 plain written", REV | 64'h0000_0A00_0000_0000);
      wr(64'h0020_0000);
      rd_chk("R8 plain follows every write", REV | 64'h0020_0000);
   endtask

   task automatic t_ignored;
      wr(64'hFFFF_FFFF_FFFF_FFFF);
      rd_chk("R11 all ones write", 64'h0000_0F08_0000_0F00);
      chk("R11 ipi after all ones", {60'b0, ipi_o}, 64'hF);
      chk("R11 iti after all ones", {60'b0, iti_o}, 64'h0);
      wr(64'h1000_0F00);
      rd_chk("R3 bit28 reads zero", REV);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_index();
      t_timer();
      t_ipi();
      t_arb();
      t_plain();
      t_ignored();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule